// File: doc/BRIEF.md
# Terminal Processor Phase Micro-Operation Executor

This block is the register half of a small terminal controller processor. Each instruction is a single byte. The byte is presented once during each of several timing phases, and each phase is marked by its own single-cycle strobe. In each phase the block looks for a different enable bit in the byte. When that bit is present, bits 6:4 select one register micro-operation. A single byte can therefore start up to three micro-operations, one per phase.

The block holds the working registers: the horizontal position X, the vertical position Y, the accumulator, the X8 toggle, the mode flag, the cursor and video flags, and the two-bit ROM bank. It also holds the sequencing flags that a neighbouring branch unit reads: done, flag-test and write. Program-counter handling and branch resolution belong to that neighbouring block. Printer operations decode as no-ops.

Top module: `tcpu_uop_exec`

## Requirements
- R1: While rst_ni is low, every register output reads zero.
- R2: On an e-strobe with opcode bit 3 = 1 and bit 7 = 0, selector bits 6:4 act as follows: 0 zeroes X and Y, 1 toggles X8, 2 increments X and decrements Y, 3 increments X, 4 zeroes AC, 5 sets mode, 6 zeroes X, 7 clears mode.
- R3: X and AC are 7 bits and wrap modulo 128. Y is YW bits and wraps modulo 2^YW.
- R4: On an f-strobe with opcode bit 2 = 1 and bit 7 = 0, the selector acts as follows: 0 decrements X and Y, 1 and 2 increment AC, 3 increments Y, 4 decrements Y, 5 increments the bank, 6 decrements X, 7 decrements AC.
- R5: On a w-strobe with opcode bits 7 and 3:0 all zero, the selector acts as follows: 0 sets cursor, 1 sets video, 2 loads Y from buf_i[YW-1:0], 4 clears cursor and video, 7 zeroes Y. Selectors 3, 5 and 6 change nothing.
- R6: An e-strobe always clears flag-test. It clears done when opcode bit 7 = 0.
- R7: A w-strobe with opcode bit 0 = 1 and bit 7 = 0 sets flag-test.
- R8: A w-strobe loads write with ((bit 7 = 1) and done = 0) or (opcode = 8'o022, 8'o042 or 8'o062). When the new write value is 1, done is set.
- R9: A g-strobe clears write.
- R10: A cycle with no strobe changes no register.
- R11: The ROM bank wraps modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | e-phase strobe |
| tf_i | input | 1 | f-phase strobe |
| tw_i | input | 1 | w-phase strobe |
| tg_i | input | 1 | g-phase strobe |
| op_i | input | 8 | Instruction byte |
| buf_i | input | 8 | Buffer data byte |
| x_o | output | 7 | X register |
| y_o | output | YW | Y register |
| ac_o | output | 7 | Accumulator |
| x8_o | output | 1 | X8 toggle |
| mode_o | output | 1 | Mode flag |
| cursor_o | output | 1 | Cursor flag |
| video_o | output | 1 | Video-process flag |
| bank_o | output | 2 | ROM bank |
| done_o | output | 1 | Done flag |
| flag_test_o | output | 1 | Flag-test flag |
| write_o | output | 1 | Write flag |

## Verification
The hardest state to reach is a w-strobe with bit 7 set while done is already 1. In that case write must drop to 0 without done changing. Reaching it takes a first w-strobe that sets done, then a second one with no clearing e-strobe between them. The directed sequence issues exactly that pair, then clears done with an e-strobe and tries again. Wrap-around of X, Y, AC and the bank is reached by decrementing from zero and by stepping the bank more than four times. Long random runs then cover the remaining interleavings.

// File: rtl/tcpu_uop_pkg.sv
package tcpu_uop_pkg;
  typedef enum logic [1:0] {XA_KEEP, XA_ZERO, XA_INC, XA_DEC} xa_op_e;
  typedef enum logic [2:0] {Y_KEEP, Y_ZERO, Y_INC, Y_DEC, Y_LOAD} y_op_e;

  typedef struct packed {
    xa_op_e x_op;
    y_op_e  y_op;
    xa_op_e ac_op;
    logic   x8_tgl;
    logic   mode_set;
    logic   mode_clr;
    logic   cur_set;
    logic   vid_set;
    logic   cv_clr;
    logic   bank_inc;
  } uop_t;
endpackage

// File: rtl/tcpu_dec_e.sv
module tcpu_dec_e
  import tcpu_uop_pkg::*;
(
  input  logic [7:0] op_i,
  output uop_t       uop_o
);
  always_comb begin
    uop_o = '0;
    if (op_i[3] && !op_i[7]) begin
      unique case (op_i[6:4])
        3'd0: begin uop_o.x_op = XA_ZERO; uop_o.y_op = Y_ZERO; end
        3'd1: uop_o.x8_tgl = 1'b1;
        3'd2: begin uop_o.x_op = XA_INC; uop_o.y_op = Y_DEC; end
        3'd3: uop_o.x_op = XA_INC;
        3'd4: uop_o.ac_op = XA_ZERO;
        3'd5: uop_o.mode_set = 1'b1;
        3'd6: uop_o.x_op = XA_ZERO;
        default: uop_o.mode_clr = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tcpu_dec_f.sv
module tcpu_dec_f
  import tcpu_uop_pkg::*;
(
  input  logic [7:0] op_i,
  output uop_t       uop_o
);
  always_comb begin
    uop_o = '0;
    if (op_i[2] && !op_i[7]) begin
      unique case (op_i[6:4])
        3'd0: begin uop_o.x_op = XA_DEC; uop_o.y_op = Y_DEC; end
        3'd1, 3'd2: uop_o.ac_op = XA_INC;
        3'd3: uop_o.y_op = Y_INC;
        3'd4: uop_o.y_op = Y_DEC;
        3'd5: uop_o.bank_inc = 1'b1;
        3'd6: uop_o.x_op = XA_DEC;
        default: uop_o.ac_op = XA_DEC;
      endcase
    end
  end
endmodule

// File: rtl/tcpu_dec_w.sv
module tcpu_dec_w
  import tcpu_uop_pkg::*;
(
  input  logic [7:0] op_i,
  output uop_t       uop_o
);
  always_comb begin
    uop_o = '0;
    if (op_i[7] == 1'b0 && op_i[3:0] == 4'd0) begin
      unique case (op_i[6:4])
        3'd0: uop_o.cur_set = 1'b1;
        3'd1: uop_o.vid_set = 1'b1;
        3'd2: uop_o.y_op = Y_LOAD;
        3'd4: uop_o.cv_clr = 1'b1;
        3'd7: uop_o.y_op = Y_ZERO;
        default: ;  // printer selectors: no register effect
      endcase
    end
  end
endmodule

// File: rtl/tcpu_uop_exec.sv
module tcpu_uop_exec
  import tcpu_uop_pkg::*;
#(
  parameter int YW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          te_i,
  input  logic          tf_i,
  input  logic          tw_i,
  input  logic          tg_i,
  input  logic [7:0]    op_i,
  input  logic [7:0]    buf_i,
  output logic [6:0]    x_o,
  output logic [YW-1:0] y_o,
  output logic [6:0]    ac_o,
  output logic          x8_o,
  output logic          mode_o,
  output logic          cursor_o,
  output logic          video_o,
  output logic [1:0]    bank_o,
  output logic          done_o,
  output logic          flag_test_o,
  output logic          write_o
);
  localparam int XW = 7;
  localparam logic [YW-1:0] Y_ONE = YW'(1);

  uop_t uop_e, uop_f, uop_w, uop;

  tcpu_dec_e u_dec_e (.op_i(op_i), .uop_o(uop_e));
  tcpu_dec_f u_dec_f (.op_i(op_i), .uop_o(uop_f));
  tcpu_dec_w u_dec_w (.op_i(op_i), .uop_o(uop_w));

  always_comb begin
    uop = '0;
    if (te_i)      uop = uop_e;
    else if (tf_i) uop = uop_f;
    else if (tw_i) uop = uop_w;
  end

  logic wr_set;
  assign wr_set = (op_i[7] && !done_o) ||
                  op_i == 8'o022 || op_i == 8'o042 || op_i == 8'o062;

  function automatic logic [XW-1:0] step7(xa_op_e o, logic [XW-1:0] v);
    unique case (o)
      XA_ZERO: step7 = '0;
      XA_INC:  step7 = v + 1'b1;
      XA_DEC:  step7 = v - 1'b1;
      default: step7 = v;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o         <= '0;
      y_o         <= '0;
      ac_o        <= '0;
      x8_o        <= 1'b0;
      mode_o      <= 1'b0;
      cursor_o    <= 1'b0;
      video_o     <= 1'b0;
      bank_o      <= '0;
      done_o      <= 1'b0;
      flag_test_o <= 1'b0;
      write_o     <= 1'b0;
    end else begin
      x_o  <= step7(uop.x_op, x_o);
      ac_o <= step7(uop.ac_op, ac_o);
      unique case (uop.y_op)
        Y_ZERO:  y_o <= '0;
        Y_INC:   y_o <= y_o + Y_ONE;
        Y_DEC:   y_o <= y_o - Y_ONE;
        Y_LOAD:  y_o <= buf_i[YW-1:0];
        default: ;
      endcase
      if (uop.x8_tgl)   x8_o   <= ~x8_o;
      if (uop.mode_set) mode_o <= 1'b1;
      if (uop.mode_clr) mode_o <= 1'b0;
      if (uop.cur_set)  cursor_o <= 1'b1;
      if (uop.vid_set)  video_o  <= 1'b1;
      if (uop.cv_clr) begin
        cursor_o <= 1'b0;
        video_o  <= 1'b0;
      end
      if (uop.bank_inc) bank_o <= bank_o + 2'd1;

      if (te_i) begin
        flag_test_o <= 1'b0;
        if (!op_i[7]) done_o <= 1'b0;
      end
      if (tw_i) begin
        if (op_i[0] && !op_i[7]) flag_test_o <= 1'b1;
        write_o <= wr_set;
        if (wr_set) done_o <= 1'b1;
      end
      if (tg_i) write_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tcpu_uop_exec_chk.sv
module tcpu_uop_exec_chk #(
  parameter int YW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          te_i,
  input logic          tf_i,
  input logic          tw_i,
  input logic          tg_i,
  input logic [7:0]    op_i,
  input logic [6:0]    x_o,
  input logic [YW-1:0] y_o,
  input logic [6:0]    ac_o,
  input logic          x8_o,
  input logic          mode_o,
  input logic          cursor_o,
  input logic          video_o,
  input logic [1:0]    bank_o,
  input logic          done_o,
  input logic          flag_test_o,
  input logic          write_o
);
  logic idle;
  assign idle = !te_i && !tf_i && !tw_i && !tg_i;

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ($stable(x_o) && $stable(y_o) && $stable(ac_o) && $stable(x8_o) &&
              $stable(mode_o) && $stable(cursor_o) && $stable(video_o) &&
              $stable(bank_o) && $stable(done_o) && $stable(flag_test_o) &&
              $stable(write_o)));

  p_e_clears_ft_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_i |=> !flag_test_o);

  p_g_clears_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg_i |=> !write_o);

  p_wr_implies_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_i |=> (!write_o || done_o));

  p_ac_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_i && op_i[7] == 1'b0 && op_i[2] && (op_i[6:4] == 3'd1 || op_i[6:4] == 3'd2))
    |=> ac_o == 7'($past(ac_o) + 7'd1));

  p_bank_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf_i && op_i[7] == 1'b0 && op_i[2] && op_i[6:4] == 3'd5)
    |=> bank_o == 2'($past(bank_o) + 2'd1));

  p_w_ft_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tw_i && op_i[0] && !op_i[7]) |=> flag_test_o);
endmodule

bind tcpu_uop_exec tcpu_uop_exec_chk #(.YW(YW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .te_i(te_i), .tf_i(tf_i), .tw_i(tw_i),
  .tg_i(tg_i), .op_i(op_i), .x_o(x_o), .y_o(y_o), .ac_o(ac_o), .x8_o(x8_o),
  .mode_o(mode_o), .cursor_o(cursor_o), .video_o(video_o), .bank_o(bank_o),
  .done_o(done_o), .flag_test_o(flag_test_o), .write_o(write_o)
);

// File: tb/tb_tcpu_uop_exec.sv
module tb_tcpu_uop_exec;
  localparam int YW = 5;
  localparam int YMOD = 1 << YW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic te_i = 0, tf_i = 0, tw_i = 0, tg_i = 0;
  logic [7:0] op_i = '0, buf_i = '0;
  logic [6:0] x_o, ac_o;
  logic [YW-1:0] y_o;
  logic x8_o, mode_o, cursor_o, video_o, done_o, flag_test_o, write_o;
  logic [1:0] bank_o;

  always #4 clk = ~clk;

  tcpu_uop_exec #(.YW(YW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .te_i(te_i), .tf_i(tf_i), .tw_i(tw_i),
    .tg_i(tg_i), .op_i(op_i), .buf_i(buf_i), .x_o(x_o), .y_o(y_o), .ac_o(ac_o),
    .x8_o(x8_o), .mode_o(mode_o), .cursor_o(cursor_o), .video_o(video_o),
    .bank_o(bank_o), .done_o(done_o), .flag_test_o(flag_test_o), .write_o(write_o)
  );

  int total = 0, bad = 0;
  int mx = 0, my = 0, mac = 0, mbank = 0;
  bit mx8 = 0, mmode = 0, mcur = 0, mvid = 0, mdone = 0, mft = 0, mwr = 0;
  bit finished = 0;

  // phase kinds: 0 idle, 1 e, 2 f, 3 w, 4 g
  function automatic void model(int kind, int op, int bv);
    int sel;
    bit b7;
    bit w;
    sel = (op >> 4) & 7;
    b7  = op[7];
    case (kind)
      1: begin
        if (op[3] && !b7) begin
          if (sel == 0) begin mx = 0; my = 0; end
          else if (sel == 1) mx8 = !mx8;
          else if (sel == 2) begin mx = (mx + 1) % 128; my = (my + YMOD - 1) % YMOD; end
          else if (sel == 3) mx = (mx + 1) % 128;
          else if (sel == 4) mac = 0;
          else if (sel == 5) mmode = 1;
          else if (sel == 6) mx = 0;
          else mmode = 0;
        end
        mft = 0;
        if (!b7) mdone = 0;
      end
      2: if (op[2] && !b7) begin
        if (sel == 0) begin mx = (mx + 127) % 128; my = (my + YMOD - 1) % YMOD; end
        else if (sel == 1 || sel == 2) mac = (mac + 1) % 128;
        else if (sel == 3) my = (my + 1) % YMOD;
        else if (sel == 4) my = (my + YMOD - 1) % YMOD;
        else if (sel == 5) mbank = (mbank + 1) % 4;
        else if (sel == 6) mx = (mx + 127) % 128;
        else mac = (mac + 127) % 128;
      end
      3: begin
        if ((op & 8'o217) == 0) begin
          if (sel == 0) mcur = 1;
          else if (sel == 1) mvid = 1;
          else if (sel == 2) my = bv % YMOD;
          else if (sel == 4) begin mcur = 0; mvid = 0; end
          else if (sel == 7) my = 0;
        end
        if (op[0] && !b7) mft = 1;
        w = (b7 && !mdone) || op == 8'o022 || op == 8'o042 || op == 8'o062;
        mwr = w;
        if (w) mdone = 1;
      end
      4: mwr = 0;
      default: ;
    endcase
  endfunction

  task automatic check(string tag);
    total++;
    if (x_o !== 7'(mx) || y_o !== YW'(my) || ac_o !== 7'(mac) || x8_o !== mx8 ||
        mode_o !== mmode || cursor_o !== mcur || video_o !== mvid ||
        bank_o !== 2'(mbank) || done_o !== mdone || flag_test_o !== mft ||
        write_o !== mwr) begin
      bad++;
      $display("FAIL %s act x=%0d y=%0d ac=%0d x8=%0b m=%0b c=%0b v=%0b bk=%0d d=%0b ft=%0b w=%0b exp x=%0d y=%0d ac=%0d x8=%0b m=%0b c=%0b v=%0b bk=%0d d=%0b ft=%0b w=%0b",
               tag, x_o, y_o, ac_o, x8_o, mode_o, cursor_o, video_o, bank_o,
               done_o, flag_test_o, write_o, mx, my, mac, mx8, mmode, mcur, mvid,
               mbank, mdone, mft, mwr);
    end
  endtask

  // drive at a negedge, check at the following negedge
  task automatic step(int kind, int op, int bv, string tag);
    te_i = (kind == 1); tf_i = (kind == 2); tw_i = (kind == 3); tg_i = (kind == 4);
    op_i = 8'(op); buf_i = 8'(bv);
    model(kind, op, bv);
    @(negedge clk);
    te_i = 0; tf_i = 0; tw_i = 0; tg_i = 0;
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step(2, 8'h64, 0, "R3 X dec wrap");
    step(1, 8'h38, 0, "R3 X inc wrap");
    step(2, 8'h74, 0, "R3 AC dec wrap");
    step(2, 8'h14, 0, "R4 AC inc sel1");
    step(2, 8'h24, 0, "R4 AC inc sel2");
    step(2, 8'h44, 0, "R3 Y dec wrap");
    step(2, 8'h34, 0, "R4 Y inc");
    step(2, 8'h04, 0, "R4 XY dec");
    step(1, 8'h28, 0, "R2 X inc Y dec");
    step(1, 8'h08, 0, "R2 zero XY");
    step(1, 8'h18, 0, "R2 X8 toggle");
    step(1, 8'h58, 0, "R2 mode set");
    step(1, 8'h78, 0, "R2 mode clr");
    step(2, 8'h74, 0, "R4 AC dec");
    step(1, 8'h48, 0, "R2 AC zero");
    step(1, 8'h68, 0, "R2 X zero");
    step(1, 8'h88, 0, "R2 bit7 blocks");
    for (int i = 0; i < 5; i++) step(2, 8'h54, 0, "R11 bank step");
    step(3, 8'h00, 0, "R5 cursor set");
    step(3, 8'h10, 0, "R5 video set");
    step(3, 8'h20, 8'hFF, "R5 Y load masked");
    step(3, 8'h30, 0, "R5 sel3 nop");
    step(3, 8'h50, 0, "R5 sel5 nop");
    step(3, 8'h60, 0, "R5 sel6 nop");
    step(3, 8'h40, 0, "R5 cv clear");
    step(3, 8'h70, 0, "R5 Y zero");
    step(3, 8'h01, 0, "R7 ft set");
    step(1, 8'h00, 0, "R6 ft and done clear");
    step(3, 8'h80, 0, "R8 write from bit7");
    step(0, 0, 0, "R10 idle");
    step(4, 0, 0, "R9 write clear");
    step(3, 8'h80, 0, "R8 done blocks write");
    step(1, 8'h80, 0, "R6 bit7 keeps done");
    step(1, 8'h00, 0, "R6 done clear");
    step(3, 8'o022, 0, "R8 octal 022");
    step(3, 8'o042, 0, "R8 octal 042");
    step(3, 8'o062, 0, "R8 octal 062");
    step(4, 0, 0, "R9 clear again");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R10 idle run");
    for (int i = 0; i < 4000; i++)
      step(int'($urandom_range(0, 4)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), "RND mix");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule